// File: doc/BRIEF.md
# Acknowledged Message Transmitter

This block sends short request and reply messages from one node to another over a byte-wide ready/valid link. It keeps each message until the receiving node acknowledges it. A host presents a message for one cycle: a 2-bit kind, a 5-bit destination node, a 5-bit source node and a 32-bit word. The word is an address for a request and data for a reply. The block packs these fields into six bytes, adds a one-byte additive checksum and sends the seven-byte frame.

For a request or a reply, the block then waits for an acknowledge from a companion receiver. The acknowledge must be of the matching kind and must come from the node the message was addressed to. If no such acknowledge arrives within a fixed number of cycles, the block sends the whole frame again. After a set number of resends it gives up, pulses a failure flag and returns to idle. A message whose kind is itself an acknowledge is sent once and is not held.

Only one message is in flight at a time. The busy output tells the host when a new message can be loaded.

Top module: `ack_msg_tx`

## Requirements
- R1: After reset, busy, tx_valid and fail are all 0.
- R2: The frame is seven bytes, sent in order. The 44-bit value {kind[1:0], dest[4:0], src[4:0], word[31:0]} is followed by four zero bits. The resulting 48 bits go out as bytes 0 to 5, most significant byte first.
- R3: Byte 6 is the sum, modulo 256, of bytes 0 to 5.
- R4: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data does not change.
- R5: A load is accepted when ld_valid is 1 and busy is 0. From the next cycle, busy and tx_valid are 1. A load presented while busy is 1 has no effect on any frame sent.
- R6: Kind 00 (request) is acknowledged only by kind 10, and kind 01 (reply) only by kind 11. In both cases ack_src must equal the message's destination. A matching acknowledge seen while waiting makes busy 0 on the next cycle, and nothing is resent.
- R7: An acknowledge of the wrong kind or from the wrong source is ignored, and the frame is resent.
- R8: While waiting, if no matching acknowledge arrives for TIMEOUT_CYC cycles after the last byte is accepted, the identical frame is sent again, starting on the next cycle.
- R9: When the wait after the MAX_RETRY-th resend expires with no acknowledge, fail is 1 for exactly one cycle, busy is 0 in that cycle, and nothing more is sent.
- R10: A message of kind 10 or 11 is sent once. Busy drops on the cycle after its last byte is accepted.
- R11: A matching acknowledge in the same cycle that the wait expires takes priority: there is no resend, and busy drops.
- R12: An acknowledge that arrives while a frame is still being sent is ignored. The wait that follows still ends in a resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Host load strobe |
| ld_kind | input | 2 | Message kind |
| ld_dest | input | 5 | Destination node ID |
| ld_src | input | 5 | Source node ID |
| ld_word | input | 32 | Address or data word |
| busy | output | 1 | A message is outstanding |
| tx_data | output | 8 | Link byte |
| tx_valid | output | 1 | Link byte valid |
| tx_ready | input | 1 | Link accepts byte |
| ack_valid | input | 1 | Received acknowledge strobe |
| ack_kind | input | 2 | Kind of the received acknowledge |
| ack_src | input | 5 | Source node of the received acknowledge |
| fail | output | 1 | One-cycle pulse when retries are exhausted |

## Verification
The two events that can fall on the same cycle are a matching acknowledge and expiry of the wait timer. To provoke this, the bench counts idle cycles after a frame and drives the acknowledge on exactly the final cycle of the wait. It then confirms that busy drops and that no byte appears for several cycles. A second race is an acknowledge held high throughout the sending of a frame and dropped just before the wait begins. That case passes only if a full resend follows after the timeout.

// File: rtl/ack_msg_tx.sv
module ack_msg_tx #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int MAX_RETRY   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [1:0]  ld_kind,
  input  logic [4:0]  ld_dest,
  input  logic [4:0]  ld_src,
  input  logic [31:0] ld_word,
  output logic        busy,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        ack_valid,
  input  logic [1:0]  ack_kind,
  input  logic [4:0]  ack_src,
  output logic        fail
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int RW = $clog2(MAX_RETRY + 1) < 1 ? 1 : $clog2(MAX_RETRY + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;

  st_t          st;
  logic [43:0]  msg;
  logic [2:0]   idx;
  logic [TW-1:0] tmr;
  logic [RW-1:0] tries;

  wire [47:0] frm  = {msg, 4'b0000};
  wire [7:0]  csum = frm[47:40] + frm[39:32] + frm[31:24] +
                     frm[23:16] + frm[15:8]  + frm[7:0];

  wire ack_hit = (st == S_WAIT) && ack_valid &&
                 (ack_kind == {1'b1, msg[42]}) && (ack_src == msg[41:37]);
  wire expire  = (st == S_WAIT) && (tmr == TW'(TIMEOUT_CYC - 1));

  assign busy     = (st != S_IDLE);
  assign tx_valid = (st == S_SEND);

  always_comb begin
    case (idx)
      3'd0:    tx_data = frm[47:40];
      3'd1:    tx_data = frm[39:32];
      3'd2:    tx_data = frm[31:24];
      3'd3:    tx_data = frm[23:16];
      3'd4:    tx_data = frm[15:8];
      3'd5:    tx_data = frm[7:0];
      3'd6:    tx_data = csum;
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      msg   <= '0;
      idx   <= '0;
      tmr   <= '0;
      tries <= '0;
      fail  <= 1'b0;
    end else begin
      fail <= 1'b0;
      case (st)
        S_IDLE: if (ld_valid) begin
          msg   <= {ld_kind, ld_dest, ld_src, ld_word};
          idx   <= '0;
          tries <= '0;
          st    <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          if (idx == 3'd6) begin
            idx <= '0;
            tmr <= '0;
            st  <= msg[43] ? S_IDLE : S_WAIT;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_WAIT: begin
          if (ack_hit) begin
            st <= S_IDLE;
          end else if (expire) begin
            if (tries == RW'(MAX_RETRY)) begin
              fail <= 1'b1;
              st   <= S_IDLE;
            end else begin
              tries <= tries + 1'b1;
              st    <= S_SEND;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ack_msg_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       fail
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
  p_load_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ld_valid |=> busy && tx_valid);
  p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  p_fail_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy);
endmodule

bind ack_msg_tx ack_msg_tx_chk u_chk (.*);

// File: tb/ack_msg_tx_test.sv
module ack_msg_tx_test;
  localparam int CLK_P = 10;
  localparam int TO    = 20;
  localparam int MR    = 2;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0;
  logic [1:0] ld_kind = 0;
  logic [4:0] ld_dest = 0, ld_src = 0;
  logic [31:0] ld_word = 0;
  logic busy, tx_valid, fail;
  logic [7:0] tx_data;
  logic tx_ready = 1;
  logic ack_valid = 0;
  logic [1:0] ack_kind = 0;
  logic [4:0] ack_src = 0;

  int checks = 0, errs = 0, cyc = 0;

  ack_msg_tx #(.TIMEOUT_CYC(TO), .MAX_RETRY(MR)) uut (.*);

  always #(CLK_P/2) clk = ~clk;

  localparam logic [43:0] VEC [4] = '{
    {2'b00, 5'd3,  5'd1,  32'h1234_5678},
    {2'b01, 5'd31, 5'd0,  32'hFFFF_FFFF},
    {2'b00, 5'd0,  5'd17, 32'h0000_0000},
    {2'b01, 5'd9,  5'd22, 32'hA5C3_0F81}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [43:0] m, input int i);
    logic [47:0] f;
    logic [7:0] s;
    f = {m, 4'b0};
    s = 0;
    for (int k = 0; k < 6; k++) s += f[47-8*k -: 8];
    return (i == 6) ? s : f[47-8*i -: 8];
  endfunction

  task automatic load(input logic [43:0] m);
    ld_kind = m[43:42]; ld_dest = m[41:37]; ld_src = m[36:32]; ld_word = m[31:0];
    ld_valid = 1;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic collect(input logic [43:0] m, input string tag, output int gap);
    gap = 0;
    while (!tx_valid && gap < 1000) begin gap++; @(negedge clk); end
    for (int i = 0; i < 7; i++) begin
      chk(tx_valid && tx_data == exp_byte(m, i), tag, tx_data, exp_byte(m, i));
      @(negedge clk);
    end
  endtask

  task automatic ack(input logic [1:0] k, input logic [4:0] s);
    ack_valid = 1; ack_kind = k; ack_src = s;
    @(negedge clk);
    ack_valid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    int g;
    logic [43:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_valid && !fail, "R1 reset", {busy, tx_valid, fail}, 0);

    // R2 R3 R6: table of vectors, each acknowledged correctly
    for (int v = 0; v < 4; v++) begin
      load(VEC[v]);
      chk(busy && tx_valid, "R5 load starts", {busy, tx_valid}, 3);
      collect(VEC[v], "R2/R3 frame byte", g);
      chk(busy, "R6 waiting", busy, 1);
      ack({1'b1, VEC[v][42]}, VEC[v][41:37]);
      chk(!busy && !tx_valid, "R6 matching ack ends", busy, 0);
    end

    // R4 backpressure
    m = {2'b00, 5'd5, 5'd6, 32'hDEAD_BEEF};
    tx_ready = 0;
    load(m);
    for (int i = 0; i < 3; i++) begin
      chk(tx_valid && tx_data == exp_byte(m, 0), "R4 hold", tx_data, exp_byte(m, 0));
      @(negedge clk);
    end
    tx_ready = 1;
    collect(m, "R4 frame after stall", g);
    ack(2'b10, 5'd5);

    // R7 wrong acks, R5 load while busy ignored, R8 resend
    m = {2'b01, 5'd12, 5'd4, 32'h0BAD_F00D};
    load(m);
    collect(m, "R7 first frame", g);
    ack(2'b10, 5'd12);
    ack(2'b11, 5'd13);
    ld_kind = 2'b00; ld_dest = 5'd1; ld_src = 5'd1; ld_word = 32'h1111_1111;
    ld_valid = 1; @(negedge clk); ld_valid = 0;
    chk(busy, "R7 wrong ack ignored", busy, 1);
    collect(m, "R5/R8 resend frame", g);
    chk(g == TO - 3, "R8 timeout length", g, TO - 3);
    collect(m, "R8 second resend", g);
    chk(g == TO, "R8 full wait", g, TO);

    // R9 give up after MR resends
    repeat (TO) @(negedge clk);
    chk(fail && !busy, "R9 fail pulse", {fail, busy}, 2);
    @(negedge clk);
    chk(!fail && !tx_valid, "R9 fail one cycle", {fail, tx_valid}, 0);

    // R10 ack-kind message sent once
    m = {2'b10, 5'd7, 5'd8, 32'h0000_00AA};
    load(m);
    collect(m, "R10 frame", g);
    chk(!busy, "R10 no wait", busy, 0);

    // R11 ack on expiry cycle
    m = {2'b00, 5'd20, 5'd2, 32'h7777_0001};
    load(m);
    collect(m, "R11 frame", g);
    repeat (TO - 1) @(negedge clk);
    chk(busy && !tx_valid, "R11 still waiting", busy, 1);
    ack(2'b10, 5'd20);
    chk(!busy, "R11 ack wins", busy, 0);
    repeat (4) begin
      chk(!tx_valid, "R11 no resend", tx_valid, 0);
      @(negedge clk);
    end

    // R12 ack during send ignored
    m = {2'b01, 5'd15, 5'd3, 32'h2468_ACE0};
    load(m);
    for (int i = 0; i < 7; i++) begin
      ack_valid = (i < 6); ack_kind = 2'b11; ack_src = 5'd15;
      chk(tx_data == exp_byte(m, i), "R12 frame", tx_data, exp_byte(m, i));
      @(negedge clk);
    end
    ack_valid = 0;
    chk(busy, "R12 ack ignored", busy, 1);
    collect(m, "R12 resend", g);
    chk(g == TO, "R12 resend timing", g, TO);
    ack(2'b11, 5'd15);
    chk(!busy, "R12 final ack", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule